// File: doc/BRIEF.md
# Self-Placing Connection Lookup Store

This block is the connection table of a time-slot switch. Each of its 512 locations holds one connection: a 12-bit stream/slot key, a 9-bit pointer into a separate sample memory, 3 control bits (bus direction, pattern mode, buffer select), 2 subrate bits and a vacancy bit. The host never chooses where a connection goes. A make command places the connection in the lowest-numbered vacant location and reports which one. A break command finds a connection by its key alone and frees it. A query command reads a location back by its physical index.

Alongside the host commands, a lookup port is presented with the current stream/slot key on each time slot. One cycle later it reports the pointer and control bits of the lowest-numbered occupied location holding that key. A pattern-mode entry is a half connection: its stored pointer byte is itself the output data, and no memory read is needed.

The command controller is a five-state machine. ST_IDLE accepts a command and moves to ST_ALLOC (make), ST_SEARCH (break) or ST_READ (query). Each of these does its work in one cycle and moves to ST_DONE. ST_DONE pulses the completion strobe and returns to ST_IDLE.

Top module: `conn_cam`

## Requirements
- R1: After reset every location is vacant (rsp_empty reads 1 for any queried index), cmd_ready is 1, and cmd_done and lk_hit are 0.
- R2: A make (cmd_op = 2'b01) accepted at a clock edge raises cmd_done for exactly one cycle, starting two edges later. The entry is written at the lowest-numbered vacant index, and that index appears on rsp_index with rsp_full = 0.
- R3: A make while no location is vacant completes with rsp_full = 1 and changes no entry.
- R4: A break (cmd_op = 2'b10) frees the lowest-numbered occupied location whose key equals cmd_key and reports that index with rsp_nomatch = 0. The next make reuses the freed location if it is the lowest vacant one.
- R5: A break whose key matches no occupied location completes with rsp_nomatch = 1 and changes no entry.
- R6: A query (cmd_op = 2'b11) returns the key, pointer, control bits, subrate bits and vacancy bit stored at cmd_idx. The vacancy bit changes only through make and break.
- R7: One cycle after lk_valid is sampled high, lk_hit reports whether an occupied location holds lk_key. On a hit, lk_index, lk_tag, lk_ctl and lk_sub come from the lowest such location; on a miss they are 0. Vacant locations never match, and lk_hit is 0 in the cycle after lk_valid is low.
- R8: Control bit 1 marks pattern mode. On a hit to such an entry, lk_pat_valid is 1 and lk_pat_data equals the low 8 bits of the stored pointer. Otherwise lk_pat_valid is 0 and lk_pat_data is 0.
- R9: cmd_ready is 0 from acceptance until the command completes. cmd_valid during that time has no effect.
- R10: cmd_op = 2'b00 is not a command: it leaves cmd_ready at 1, raises no cmd_done and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 01 make, 10 break, 11 query, 00 none |
| cmd_key | input | 12 | Stream/slot key for make and break |
| cmd_tag | input | 9 | Pointer for make |
| cmd_ctl | input | 3 | Control bits for make (bit 1 = pattern) |
| cmd_sub | input | 2 | Subrate bits for make |
| cmd_idx | input | 9 | Physical index for query |
| cmd_ready | output | 1 | Controller idle, command accepted |
| cmd_done | output | 1 | One-cycle completion strobe |
| rsp_index | output | 9 | Allocated, freed or queried index |
| rsp_full | output | 1 | Make found no vacant location |
| rsp_nomatch | output | 1 | Break found no matching entry |
| rsp_key | output | 12 | Queried key |
| rsp_tag | output | 9 | Queried pointer |
| rsp_ctl | output | 3 | Queried control bits |
| rsp_sub | output | 2 | Queried subrate bits |
| rsp_empty | output | 1 | Queried vacancy bit |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | 12 | Lookup key |
| lk_hit | output | 1 | Lookup matched |
| lk_index | output | 9 | Matching index |
| lk_tag | output | 9 | Matching pointer |
| lk_ctl | output | 3 | Matching control bits |
| lk_sub | output | 2 | Matching subrate bits |
| lk_pat_valid | output | 1 | Pattern-mode hit |
| lk_pat_data | output | 8 | Pattern byte |

## Verification
The hardest condition to reach from the ports is a full table. Every one of the 512 locations has to be occupied through its own make command before the full response can appear. The stimulus fills the table with distinct keys, tracked by an independent occupancy model. It then attempts one more make and checks that the last location still holds its entry. Finally it frees index 511 and confirms that the next make lands exactly there, which exercises the highest priority-encoder position for both allocation and lookup.

// File: rtl/conn_cam_pkg.sv
package conn_cam_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_MAKE  = 2'b01,
        OP_BREAK = 2'b10,
        OP_QUERY = 2'b11
    } cam_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALLOC,
        ST_SEARCH,
        ST_READ,
        ST_DONE
    } cam_state_e;

endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N    = 512,
    parameter int IW   = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/conn_cam_store.sv
module conn_cam_store #(
    parameter int DEPTH = 512,
    parameter int KEY_W = 12,
    parameter int TAG_W = 9,
    parameter int CTL_W = 3,
    parameter int SUB_W = 2,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [CTL_W-1:0] wr_ctl,
    input  logic [SUB_W-1:0] wr_sub,
    input  logic             clr_en,
    input  logic [IW-1:0]    clr_idx,
    input  logic [KEY_W-1:0] srch_key,
    input  logic [KEY_W-1:0] lk_key,
    output logic [DEPTH-1:0] free_vec,
    output logic [DEPTH-1:0] srch_vec,
    output logic [DEPTH-1:0] lk_vec,
    input  logic [IW-1:0]    rd_idx,
    output logic [KEY_W-1:0] rd_key,
    output logic [TAG_W-1:0] rd_tag,
    output logic [CTL_W-1:0] rd_ctl,
    output logic [SUB_W-1:0] rd_sub,
    output logic             rd_empty,
    input  logic [IW-1:0]    lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    output logic [CTL_W-1:0] lk_ctl,
    output logic [SUB_W-1:0] lk_sub
);

    logic [KEY_W-1:0] key_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [CTL_W-1:0] ctl_q [DEPTH];
    logic [SUB_W-1:0] sub_q [DEPTH];
    logic [DEPTH-1:0] empty_q;

    // Vacancy bits carry reset; payload fields need none.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= '1;
        end else begin
            if (wr_en)  empty_q[wr_idx]  <= 1'b0;
            if (clr_en) empty_q[clr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_q[wr_idx] <= wr_key;
            tag_q[wr_idx] <= wr_tag;
            ctl_q[wr_idx] <= wr_ctl;
            sub_q[wr_idx] <= wr_sub;
        end
    end

    assign free_vec = empty_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign srch_vec[g] = !empty_q[g] && (key_q[g] == srch_key);
        assign lk_vec[g]   = !empty_q[g] && (key_q[g] == lk_key);
    end

    assign rd_key   = key_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_ctl   = ctl_q[rd_idx];
    assign rd_sub   = sub_q[rd_idx];
    assign rd_empty = empty_q[rd_idx];

    assign lk_tag = tag_q[lk_idx];
    assign lk_ctl = ctl_q[lk_idx];
    assign lk_sub = sub_q[lk_idx];

endmodule

// File: rtl/conn_cam_ctrl.sv
module conn_cam_ctrl
    import conn_cam_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int KEY_W = 12,
    parameter int TAG_W = 9,
    parameter int CTL_W = 3,
    parameter int SUB_W = 2,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [KEY_W-1:0] cmd_key,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic [CTL_W-1:0] cmd_ctl,
    input  logic [SUB_W-1:0] cmd_sub,
    input  logic [IW-1:0]    cmd_idx,
    output logic             cmd_ready,
    output logic             cmd_done,
    input  logic             free_any,
    input  logic [IW-1:0]    free_idx,
    input  logic             srch_any,
    input  logic [IW-1:0]    srch_idx,
    output logic             wr_en,
    output logic [IW-1:0]    wr_idx,
    output logic [KEY_W-1:0] wr_key,
    output logic [TAG_W-1:0] wr_tag,
    output logic [CTL_W-1:0] wr_ctl,
    output logic [SUB_W-1:0] wr_sub,
    output logic             clr_en,
    output logic [IW-1:0]    clr_idx,
    output logic [KEY_W-1:0] srch_key,
    output logic [IW-1:0]    rd_idx,
    input  logic [KEY_W-1:0] rd_key,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [CTL_W-1:0] rd_ctl,
    input  logic [SUB_W-1:0] rd_sub,
    input  logic             rd_empty,
    output logic [IW-1:0]    rsp_index,
    output logic             rsp_full,
    output logic             rsp_nomatch,
    output logic [KEY_W-1:0] rsp_key,
    output logic [TAG_W-1:0] rsp_tag,
    output logic [CTL_W-1:0] rsp_ctl,
    output logic [SUB_W-1:0] rsp_sub,
    output logic             rsp_empty
);

    cam_state_e state_q, state_d;
    cam_op_e    op_in;

    logic [KEY_W-1:0] key_q;
    logic [TAG_W-1:0] tag_q;
    logic [CTL_W-1:0] ctl_q;
    logic [SUB_W-1:0] sub_q;
    logic [IW-1:0]    idx_q;

    assign op_in = cam_op_e'(cmd_op);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op_in)
                        OP_MAKE:  state_d = ST_ALLOC;
                        OP_BREAK: state_d = ST_SEARCH;
                        OP_QUERY: state_d = ST_READ;
                        OP_NONE:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_ALLOC:  state_d = ST_DONE;
            ST_SEARCH: state_d = ST_DONE;
            ST_READ:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        cmd_ready = 1'b0;
        cmd_done  = 1'b0;
        wr_en     = 1'b0;
        clr_en    = 1'b0;
        unique case (state_q)
            ST_IDLE:   cmd_ready = 1'b1;
            ST_ALLOC:  wr_en     = free_any;
            ST_SEARCH: clr_en    = srch_any;
            ST_READ:   ;
            ST_DONE:   cmd_done  = 1'b1;
            default:   ;
        endcase
    end

    assign wr_idx   = free_idx;
    assign wr_key   = key_q;
    assign wr_tag   = tag_q;
    assign wr_ctl   = ctl_q;
    assign wr_sub   = sub_q;
    assign clr_idx  = srch_idx;
    assign srch_key = key_q;
    assign rd_idx   = idx_q;

    // Command capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
            tag_q <= '0;
            ctl_q <= '0;
            sub_q <= '0;
            idx_q <= '0;
        end else if (state_q == ST_IDLE && cmd_valid) begin
            key_q <= cmd_key;
            tag_q <= cmd_tag;
            ctl_q <= cmd_ctl;
            sub_q <= cmd_sub;
            idx_q <= cmd_idx;
        end
    end

    // Response registers, held until the next command completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_index   <= '0;
            rsp_full    <= 1'b0;
            rsp_nomatch <= 1'b0;
            rsp_key     <= '0;
            rsp_tag     <= '0;
            rsp_ctl     <= '0;
            rsp_sub     <= '0;
            rsp_empty   <= 1'b1;
        end else begin
            unique case (state_q)
                ST_ALLOC: begin
                    rsp_index   <= free_any ? free_idx : '0;
                    rsp_full    <= !free_any;
                    rsp_nomatch <= 1'b0;
                end
                ST_SEARCH: begin
                    rsp_index   <= srch_any ? srch_idx : '0;
                    rsp_full    <= 1'b0;
                    rsp_nomatch <= !srch_any;
                end
                ST_READ: begin
                    rsp_index   <= idx_q;
                    rsp_full    <= 1'b0;
                    rsp_nomatch <= 1'b0;
                    rsp_key     <= rd_key;
                    rsp_tag     <= rd_tag;
                    rsp_ctl     <= rd_ctl;
                    rsp_sub     <= rd_sub;
                    rsp_empty   <= rd_empty;
                end
                ST_IDLE, ST_DONE: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/conn_cam_lookup.sv
module conn_cam_lookup #(
    parameter int DEPTH   = 512,
    parameter int TAG_W   = 9,
    parameter int CTL_W   = 3,
    parameter int SUB_W   = 2,
    parameter int PAT_BIT = 1,
    parameter int PAT_W   = 8,
    parameter int IW      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [DEPTH-1:0] lk_vec,
    output logic [IW-1:0]    rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [CTL_W-1:0] rd_ctl,
    input  logic [SUB_W-1:0] rd_sub,
    output logic             lk_hit,
    output logic [IW-1:0]    lk_index,
    output logic [TAG_W-1:0] lk_tag,
    output logic [CTL_W-1:0] lk_ctl,
    output logic [SUB_W-1:0] lk_sub,
    output logic             lk_pat_valid,
    output logic [PAT_W-1:0] lk_pat_data
);

    logic hit_any;
    logic hit_now;

    cam_prio_enc #(.N(DEPTH), .IW(IW)) u_enc (
        .req (lk_vec),
        .any (hit_any),
        .idx (rd_idx)
    );

    assign hit_now = lk_valid && hit_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_hit       <= 1'b0;
            lk_index     <= '0;
            lk_tag       <= '0;
            lk_ctl       <= '0;
            lk_sub       <= '0;
            lk_pat_valid <= 1'b0;
            lk_pat_data  <= '0;
        end else begin
            lk_hit       <= hit_now;
            lk_index     <= hit_now ? rd_idx : '0;
            lk_tag       <= hit_now ? rd_tag : '0;
            lk_ctl       <= hit_now ? rd_ctl : '0;
            lk_sub       <= hit_now ? rd_sub : '0;
            lk_pat_valid <= hit_now && rd_ctl[PAT_BIT];
            lk_pat_data  <= (hit_now && rd_ctl[PAT_BIT]) ? rd_tag[PAT_W-1:0] : '0;
        end
    end

endmodule

// File: rtl/conn_cam.sv
module conn_cam #(
    parameter int DEPTH   = 512,
    parameter int KEY_W   = 12,
    parameter int TAG_W   = 9,
    parameter int CTL_W   = 3,
    parameter int SUB_W   = 2,
    parameter int PAT_BIT = 1,
    parameter int PAT_W   = TAG_W - 1,
    parameter int IW      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [KEY_W-1:0] cmd_key,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic [CTL_W-1:0] cmd_ctl,
    input  logic [SUB_W-1:0] cmd_sub,
    input  logic [IW-1:0]    cmd_idx,
    output logic             cmd_ready,
    output logic             cmd_done,
    output logic [IW-1:0]    rsp_index,
    output logic             rsp_full,
    output logic             rsp_nomatch,
    output logic [KEY_W-1:0] rsp_key,
    output logic [TAG_W-1:0] rsp_tag,
    output logic [CTL_W-1:0] rsp_ctl,
    output logic [SUB_W-1:0] rsp_sub,
    output logic             rsp_empty,
    input  logic             lk_valid,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    output logic [IW-1:0]    lk_index,
    output logic [TAG_W-1:0] lk_tag,
    output logic [CTL_W-1:0] lk_ctl,
    output logic [SUB_W-1:0] lk_sub,
    output logic             lk_pat_valid,
    output logic [PAT_W-1:0] lk_pat_data
);

    logic [DEPTH-1:0] free_vec, srch_vec, lk_vec;
    logic             free_any, srch_any;
    logic [IW-1:0]    free_idx, srch_idx;
    logic             wr_en, clr_en;
    logic [IW-1:0]    wr_idx, clr_idx, rd_idx, lk_rd_idx;
    logic [KEY_W-1:0] wr_key, srch_key, rd_key;
    logic [TAG_W-1:0] wr_tag, rd_tag, lk_rd_tag;
    logic [CTL_W-1:0] wr_ctl, rd_ctl, lk_rd_ctl;
    logic [SUB_W-1:0] wr_sub, rd_sub, lk_rd_sub;
    logic             rd_empty;

    conn_cam_store #(
        .DEPTH(DEPTH), .KEY_W(KEY_W), .TAG_W(TAG_W),
        .CTL_W(CTL_W), .SUB_W(SUB_W), .IW(IW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_key   (wr_key),
        .wr_tag   (wr_tag),
        .wr_ctl   (wr_ctl),
        .wr_sub   (wr_sub),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .srch_key (srch_key),
        .lk_key   (lk_key),
        .free_vec (free_vec),
        .srch_vec (srch_vec),
        .lk_vec   (lk_vec),
        .rd_idx   (rd_idx),
        .rd_key   (rd_key),
        .rd_tag   (rd_tag),
        .rd_ctl   (rd_ctl),
        .rd_sub   (rd_sub),
        .rd_empty (rd_empty),
        .lk_idx   (lk_rd_idx),
        .lk_tag   (lk_rd_tag),
        .lk_ctl   (lk_rd_ctl),
        .lk_sub   (lk_rd_sub)
    );

    cam_prio_enc #(.N(DEPTH), .IW(IW)) u_free_enc (
        .req (free_vec),
        .any (free_any),
        .idx (free_idx)
    );

    cam_prio_enc #(.N(DEPTH), .IW(IW)) u_srch_enc (
        .req (srch_vec),
        .any (srch_any),
        .idx (srch_idx)
    );

    conn_cam_ctrl #(
        .DEPTH(DEPTH), .KEY_W(KEY_W), .TAG_W(TAG_W),
        .CTL_W(CTL_W), .SUB_W(SUB_W), .IW(IW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_key     (cmd_key),
        .cmd_tag     (cmd_tag),
        .cmd_ctl     (cmd_ctl),
        .cmd_sub     (cmd_sub),
        .cmd_idx     (cmd_idx),
        .cmd_ready   (cmd_ready),
        .cmd_done    (cmd_done),
        .free_any    (free_any),
        .free_idx    (free_idx),
        .srch_any    (srch_any),
        .srch_idx    (srch_idx),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_key      (wr_key),
        .wr_tag      (wr_tag),
        .wr_ctl      (wr_ctl),
        .wr_sub      (wr_sub),
        .clr_en      (clr_en),
        .clr_idx     (clr_idx),
        .srch_key    (srch_key),
        .rd_idx      (rd_idx),
        .rd_key      (rd_key),
        .rd_tag      (rd_tag),
        .rd_ctl      (rd_ctl),
        .rd_sub      (rd_sub),
        .rd_empty    (rd_empty),
        .rsp_index   (rsp_index),
        .rsp_full    (rsp_full),
        .rsp_nomatch (rsp_nomatch),
        .rsp_key     (rsp_key),
        .rsp_tag     (rsp_tag),
        .rsp_ctl     (rsp_ctl),
        .rsp_sub     (rsp_sub),
        .rsp_empty   (rsp_empty)
    );

    conn_cam_lookup #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .CTL_W(CTL_W), .SUB_W(SUB_W),
        .PAT_BIT(PAT_BIT), .PAT_W(PAT_W), .IW(IW)
    ) u_lookup (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_valid     (lk_valid),
        .lk_vec       (lk_vec),
        .rd_idx       (lk_rd_idx),
        .rd_tag       (lk_rd_tag),
        .rd_ctl       (lk_rd_ctl),
        .rd_sub       (lk_rd_sub),
        .lk_hit       (lk_hit),
        .lk_index     (lk_index),
        .lk_tag       (lk_tag),
        .lk_ctl       (lk_ctl),
        .lk_sub       (lk_sub),
        .lk_pat_valid (lk_pat_valid),
        .lk_pat_data  (lk_pat_data)
    );

endmodule

// File: rtl/conn_cam_chk.sv
module conn_cam_chk #(
    parameter int DEPTH   = 512,
    parameter int KEY_W   = 12,
    parameter int TAG_W   = 9,
    parameter int CTL_W   = 3,
    parameter int SUB_W   = 2,
    parameter int PAT_BIT = 1,
    parameter int PAT_W   = TAG_W - 1,
    parameter int IW      = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             cmd_ready,
    input logic             cmd_done,
    input logic             rsp_full,
    input logic             rsp_nomatch,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic [CTL_W-1:0] lk_ctl,
    input logic             lk_pat_valid,
    input logic [PAT_W-1:0] lk_pat_data
);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op != 2'b00) |=> !cmd_ready);

    assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op != 2'b00) |=> ##1 cmd_done);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    assert_nop_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'b00) |=> (cmd_ready && !cmd_done));

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !(rsp_full && rsp_nomatch));

    assert_no_lookup_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_hit);

    assert_pattern_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pat_valid |-> (lk_hit && lk_ctl[PAT_BIT]));

    assert_pattern_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_pat_valid |-> (lk_pat_data == '0));

endmodule

bind conn_cam conn_cam_chk #(
    .DEPTH(DEPTH), .KEY_W(KEY_W), .TAG_W(TAG_W), .CTL_W(CTL_W),
    .SUB_W(SUB_W), .PAT_BIT(PAT_BIT), .PAT_W(PAT_W), .IW(IW)
) u_chk (.*);

// File: tb/conn_cam_tb_top.sv
module conn_cam_tb_top;

    localparam int DEPTH = 512;
    localparam int IW    = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [11:0] cmd_key = '0;
    logic [8:0]  cmd_tag = '0;
    logic [2:0]  cmd_ctl = '0;
    logic [1:0]  cmd_sub = '0;
    logic [8:0]  cmd_idx = '0;
    logic        cmd_ready, cmd_done;
    logic [8:0]  rsp_index;
    logic        rsp_full, rsp_nomatch;
    logic [11:0] rsp_key;
    logic [8:0]  rsp_tag;
    logic [2:0]  rsp_ctl;
    logic [1:0]  rsp_sub;
    logic        rsp_empty;
    logic        lk_valid = 1'b0;
    logic [11:0] lk_key = '0;
    logic        lk_hit;
    logic [8:0]  lk_index, lk_tag;
    logic [2:0]  lk_ctl;
    logic [1:0]  lk_sub;
    logic        lk_pat_valid;
    logic [7:0]  lk_pat_data;

    always #2.5 clk = ~clk;

    conn_cam dut_i (.*);

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0] op;
        logic [8:0] index; logic full; logic nomatch;
        logic [11:0] key; logic [8:0] tag; logic [2:0] ctl; logic [1:0] sub; logic empty;
        string req;
    } cmd_exp_t;

    typedef struct {
        logic hit; logic [8:0] index; logic [8:0] tag; logic [2:0] ctl; logic [1:0] sub;
        logic pat; logic [7:0] pdata; string req;
    } lk_exp_t;

    cmd_exp_t cmd_q[$];
    lk_exp_t  lk_q[$];

    // reference model of the table
    logic [11:0] m_key [DEPTH];
    logic [8:0]  m_tag [DEPTH];
    logic [2:0]  m_ctl [DEPTH];
    logic [1:0]  m_sub [DEPTH];
    bit          m_empty [DEPTH];

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Driver: compute expectation, push it, drive the command
    task automatic issue(logic [1:0] op, logic [11:0] key, logic [8:0] tag,
                         logic [2:0] ctl, logic [1:0] sub, logic [8:0] idx, string req);
        cmd_exp_t e;
        int found;
        e = '{op: op, index: '0, full: 0, nomatch: 0, key: '0, tag: '0, ctl: '0,
              sub: '0, empty: 1'b0, req: req};
        found = -1;
        if (op == 2'b01) begin
            for (int i = 0; i < DEPTH; i++) if (found < 0 && m_empty[i]) found = i;
            if (found < 0) e.full = 1;
            else begin
                e.index = 9'(found);
                m_empty[found] = 0; m_key[found] = key; m_tag[found] = tag;
                m_ctl[found] = ctl; m_sub[found] = sub;
            end
        end else if (op == 2'b10) begin
            for (int i = 0; i < DEPTH; i++)
                if (found < 0 && !m_empty[i] && m_key[i] == key) found = i;
            if (found < 0) e.nomatch = 1;
            else begin e.index = 9'(found); m_empty[found] = 1; end
        end else begin
            e.index = idx; e.empty = m_empty[idx];
            e.key = m_key[idx]; e.tag = m_tag[idx]; e.ctl = m_ctl[idx]; e.sub = m_sub[idx];
        end
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = op; cmd_key = key; cmd_tag = tag;
        cmd_ctl = ctl; cmd_sub = sub; cmd_idx = idx;
        cmd_q.push_back(e);
        @(posedge clk); #1;
        cmd_valid = 0;
        @(negedge clk);
        check(!cmd_done && !cmd_ready, "R2", "busy cycle done/ready", {cmd_done, cmd_ready}, 0);
        @(negedge clk);
        check(cmd_done, "R2", "done after two edges", cmd_done, 1);
    endtask

    task automatic lookup(logic [11:0] key, string req);
        lk_exp_t e;
        int found;
        found = -1;
        for (int i = 0; i < DEPTH; i++)
            if (found < 0 && !m_empty[i] && m_key[i] == key) found = i;
        e = '{hit: 0, index: '0, tag: '0, ctl: '0, sub: '0, pat: 0, pdata: '0, req: req};
        if (found >= 0) begin
            e.hit = 1; e.index = 9'(found); e.tag = m_tag[found];
            e.ctl = m_ctl[found]; e.sub = m_sub[found];
            e.pat = m_ctl[found][1];
            e.pdata = e.pat ? m_tag[found][7:0] : 8'h00;
        end
        @(posedge clk); #1;
        lk_valid = 1; lk_key = key;
        lk_q.push_back(e);
        @(posedge clk); #1;
        lk_valid = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops and compares as results appear
    bit lk_pend = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_done) begin
                if (cmd_q.size() == 0)
                    check(0, "R9", "unexpected completion", 1, 0);
                else begin
                    cmd_exp_t e;
                    e = cmd_q.pop_front();
                    if (e.op == 2'b01) begin
                        check(rsp_full == e.full, e.req, "make full flag", rsp_full, e.full);
                        if (!e.full) check(rsp_index == e.index, e.req, "make index", rsp_index, e.index);
                    end else if (e.op == 2'b10) begin
                        check(rsp_nomatch == e.nomatch, e.req, "break nomatch", rsp_nomatch, e.nomatch);
                        if (!e.nomatch) check(rsp_index == e.index, e.req, "break index", rsp_index, e.index);
                    end else begin
                        check(rsp_empty == e.empty, e.req, "query empty", rsp_empty, e.empty);
                        if (!e.empty)
                            check({rsp_key, rsp_tag, rsp_ctl, rsp_sub} == {e.key, e.tag, e.ctl, e.sub},
                                  e.req, "query fields", {rsp_key, rsp_tag, rsp_ctl, rsp_sub},
                                  {e.key, e.tag, e.ctl, e.sub});
                    end
                end
            end
            if (lk_pend) begin
                lk_exp_t e;
                e = lk_q.pop_front();
                check(lk_hit == e.hit, e.req, "lookup hit", lk_hit, e.hit);
                check({lk_index, lk_tag, lk_ctl, lk_sub} == {e.index, e.tag, e.ctl, e.sub},
                      e.req, "lookup fields", {lk_index, lk_tag, lk_ctl, lk_sub},
                      {e.index, e.tag, e.ctl, e.sub});
                check({lk_pat_valid, lk_pat_data} == {e.pat, e.pdata}, "R8", "pattern output",
                      {lk_pat_valid, lk_pat_data}, {e.pat, e.pdata});
            end
            lk_pend = lk_valid;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R1", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        int last_idx;
        logic [11:0] last_key;
        for (int i = 0; i < DEPTH; i++) begin
            m_empty[i] = 1; m_key[i] = '0; m_tag[i] = '0; m_ctl[i] = '0; m_sub[i] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(cmd_ready && !cmd_done && !lk_hit, "R1", "reset outputs",
              {cmd_ready, cmd_done, lk_hit}, 3'b100);
        issue(2'b11, 0, 0, 0, 0, 9'd0,   "R1");
        issue(2'b11, 0, 0, 0, 0, 9'd511, "R1");

        // R2 allocation order
        issue(2'b01, 12'h123, 9'h0A5, 3'b100, 2'd2, 0, "R2");
        issue(2'b01, 12'h045, 9'h13C, 3'b010, 2'd1, 0, "R2");
        issue(2'b01, 12'h123, 9'h1FF, 3'b001, 2'd3, 0, "R2");
        // R6 query
        issue(2'b11, 0, 0, 0, 0, 9'd1, "R6");
        issue(2'b11, 0, 0, 0, 0, 9'd2, "R6");
        issue(2'b11, 0, 0, 0, 0, 9'd3, "R6");
        // R7 / R8 lookups
        lookup(12'h123, "R7");
        lookup(12'h045, "R8");
        lookup(12'h777, "R7");
        // R4 break then reuse
        issue(2'b10, 12'h123, 0, 0, 0, 0, "R4");
        lookup(12'h123, "R7");
        issue(2'b11, 0, 0, 0, 0, 9'd0, "R4");
        issue(2'b01, 12'h0F0, 9'h0C3, 3'b110, 2'd0, 0, "R4");
        lookup(12'h0F0, "R8");
        // R5 break miss
        issue(2'b10, 12'h999, 0, 0, 0, 0, "R5");
        lookup(12'h045, "R5");

        // R9 command held valid while busy
        begin
            @(negedge clk);
            while (!cmd_ready) @(negedge clk);
            @(posedge clk); #1;
            cmd_valid = 1; cmd_op = 2'b01; cmd_key = 12'h555; cmd_tag = 9'h011;
            cmd_ctl = 3'b000; cmd_sub = 2'd0;
            cmd_q.push_back('{op: 2'b01, index: 9'd3, full: 0, nomatch: 0, key: '0, tag: '0,
                              ctl: '0, sub: '0, empty: 0, req: "R9"});
            m_empty[3] = 0; m_key[3] = 12'h555; m_tag[3] = 9'h011; m_ctl[3] = 0; m_sub[3] = 0;
            @(posedge clk); #1;
            cmd_key = 12'h666; cmd_tag = 9'h022;
            @(posedge clk); #1;
            @(posedge clk); #1;
            cmd_valid = 0;
            repeat (3) @(negedge clk);
            check(cmd_ready, "R9", "ready after busy", cmd_ready, 1);
        end
        lookup(12'h666, "R9");
        lookup(12'h555, "R9");
        issue(2'b11, 0, 0, 0, 0, 9'd4, "R9");

        // R10 op 00
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = 2'b00; cmd_key = 12'h777;
        @(posedge clk); #1;
        cmd_valid = 0;
        @(negedge clk);
        check(cmd_ready && !cmd_done, "R10", "no-op stays idle", {cmd_ready, cmd_done}, 2'b10);
        @(negedge clk);
        check(!cmd_done, "R10", "no-op no completion", cmd_done, 0);
        issue(2'b11, 0, 0, 0, 0, 9'd4, "R10");

        // R3 fill the table
        last_idx = 0; last_key = '0;
        for (int n = 0; n < DEPTH; n++) begin
            bit any_free;
            any_free = 0;
            for (int i = 0; i < DEPTH; i++) if (m_empty[i]) any_free = 1;
            if (any_free) begin
                last_key = 12'h800 | 12'(n);
                issue(2'b01, last_key, 9'(n), 3'b000, 2'(n), 0, "R3");
            end
        end
        issue(2'b01, 12'hABC, 9'h055, 3'b010, 2'd1, 0, "R3");
        issue(2'b11, 0, 0, 0, 0, 9'd511, "R3");
        lookup(12'hABC, "R3");
        lookup(last_key, "R7");
        issue(2'b10, last_key, 0, 0, 0, 0, "R4");
        issue(2'b01, 12'h3A7, 9'h1A5, 3'b010, 2'd2, 0, "R4");
        lookup(12'h3A7, "R8");
        issue(2'b11, 0, 0, 0, 0, 9'd511, "R6");

        repeat (5) @(negedge clk);
        check(cmd_q.size() == 0 && lk_q.size() == 0, "R2", "all results observed",
              cmd_q.size() + lk_q.size(), 0);
        summary();
    end

endmodule